// File: doc/BRIEF.md
# Lockstep Pair Checker and Recovery Sequencer

This block sits beside two processors that execute the same program in lockstep. Every clock it compares the output words the two cores present, qualified by each core's valid strobe. The result is merged with fault flags raised by neighbouring interface blocks into one fault condition. A first fault makes the block request a program rollback or restart. It holds that request until the recovery logic reports completion. It then watches the pair for a fixed number of cycles.

A fault inside that watch window is a recurrence. A recurrence either shuts the module down, halting both cores and removing the module's outputs from the bus, or drops to a degraded single-core mode when the degraded-mode enable is set. In degraded mode the output path carries only the core named by the healthy-select input, comparison is switched off, and only an external fault can still stop the module. The compare path is built from several identical comparator copies. The pair counts as clean only when every copy reports agreement.

Top module: `lockstep_guard`

## Requirements
- R1: In normal mode, a cycle in which both valid strobes are high and the two data words differ counts as a fault; on the following clock the mode becomes recovery (status code 1) and `rollback_req` goes high. Equal words with both strobes high raise no fault, and `out_data` then carries core A's word.
- R2: A valid strobe high on only one side counts as a fault just like a data mismatch. Both strobes low is no fault, whatever the data.
- R3: Any bit of `ext_fault` high in normal mode counts as a fault and moves the block into recovery on the next clock.
- R4: In recovery, `rollback_req` stays high and further faults are ignored until `recov_done` is sampled high. The mode then becomes watch (status code 2) and `rollback_req` drops.
- R5: The watch mode lasts exactly WATCH_CYCLES fault-free clocks and then returns to normal (status code 0), so a later fault starts again from the first escalation stage.
- R6: A fault during watch with `degrade_en` low moves the block to halted (status code 4). From the first cycle of that mode, `halt` is high, `out_en` is low, `out_valid` is low and `sel_proc` is 00.
- R7: The halted mode is left only by reset; `recov_done`, faults, `degrade_en` and `healthy_sel` have no effect on it.
- R8: A fault during watch with `degrade_en` high moves the block to degraded (status code 3). In that mode comparison is off, so mismatches and one-sided strobes are ignored. `out_data` and `out_valid` come from core A when `healthy_sel` is 0 and from core B when it is 1. `sel_proc` is one-hot with bit 0 for A and bit 1 for B.
- R9: Any `ext_fault` bit high in degraded mode moves the block to halted on the next clock.
- R10: After reset, the mode is normal (status code 0), `out_en` is high, `halt` and `rollback_req` are low, and `sel_proc` is 11 (both cores in service).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_data | input | DATA_W | Output word of core A |
| a_valid | input | 1 | Core A word valid |
| b_data | input | DATA_W | Output word of core B |
| b_valid | input | 1 | Core B word valid |
| ext_fault | input | N_EXT | Fault flags from neighbouring interface blocks |
| recov_done | input | 1 | Rollback or restart has completed |
| degrade_en | input | 1 | On recurrence, continue on one core instead of halting |
| healthy_sel | input | 1 | Core kept in degraded mode: 0 = A, 1 = B |
| rollback_req | output | 1 | Rollback or restart request |
| halt | output | 1 | Halt both cores |
| out_en | output | 1 | Module bus output enable |
| out_data | output | DATA_W | Word forwarded to the bus |
| out_valid | output | 1 | Forwarded word valid |
| sel_proc | output | 2 | Cores in service, bit 0 = A, bit 1 = B |
| fault_status | output | 3 | Mode code: 0 normal, 1 recovery, 2 watch, 3 degraded, 4 halted |

## Verification
The bench builds the block with a 16-bit data path, two external fault inputs and a watch window of 16 cycles instead of the default 1024. The short window brings its exact expiry, with the last watch cycle and the first normal cycle, within a few dozen clocks. That leaves room to reach both recurrence outcomes, degraded and halted, and to show that a halted module ignores everything after it. Two comparator copies keep the duplicated compare path at its default shape.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    typedef enum logic [2:0] {
        LSG_NORMAL   = 3'd0,
        LSG_RECOVER  = 3'd1,
        LSG_WATCH    = 3'd2,
        LSG_DEGRADED = 3'd3,
        LSG_HALTED   = 3'd4
    } lsg_mode_e;

endpackage

// File: rtl/lsg_cmp.sv
module lsg_cmp #(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_valid,
    output logic              miss
);

    logic strobe_split;
    logic word_diff;

    always_comb begin
        strobe_split = a_valid ^ b_valid;
        word_diff    = a_valid && b_valid && (a_data != b_data);
        miss         = en && (strobe_split || word_diff);
    end

endmodule

// File: rtl/lsg_ctrl.sv
module lsg_ctrl
    import lsg_pkg::*;
#(
    parameter int WATCH_CYCLES = 1024
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmp_fault,
    input  logic      ext_any,
    input  logic      recov_done,
    input  logic      degrade_en,
    output lsg_mode_e mode
);

    localparam int CW = (WATCH_CYCLES > 1) ? $clog2(WATCH_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WATCH_CYCLES - 1);

    typedef struct packed {
        lsg_mode_e     mode;
        logic [CW-1:0] cnt;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  fault_any;

    always_comb begin
        fault_any = cmp_fault || ext_any;
        st_d      = st_q;
        case (st_q.mode)
            LSG_NORMAL: begin
                if (fault_any) begin
                    st_d.mode = LSG_RECOVER;
                end
            end
            LSG_RECOVER: begin
                if (recov_done) begin
                    st_d.mode = LSG_WATCH;
                    st_d.cnt  = '0;
                end
            end
            LSG_WATCH: begin
                if (fault_any) begin
                    st_d.mode = degrade_en ? LSG_DEGRADED : LSG_HALTED;
                    st_d.cnt  = '0;
                end else if (st_q.cnt == LAST) begin
                    st_d.mode = LSG_NORMAL;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            LSG_DEGRADED: begin
                if (ext_any) begin
                    st_d.mode = LSG_HALTED;
                end
            end
            LSG_HALTED: begin
                st_d.mode = LSG_HALTED;
            end
            default: begin
                st_d.mode = LSG_HALTED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: LSG_NORMAL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    AST_NORMAL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LSG_NORMAL && (cmp_fault || ext_any)) |=> st_q.mode == LSG_RECOVER); // R1
    AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LSG_RECOVER && !recov_done) |=> st_q.mode == LSG_RECOVER); // R4
    AST_WATCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == LSG_WATCH |-> st_q.cnt <= LAST); // R5
    AST_RECUR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LSG_WATCH && (cmp_fault || ext_any) && !degrade_en) |=> st_q.mode == LSG_HALTED); // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == LSG_HALTED |=> st_q.mode == LSG_HALTED); // R7
    AST_DEGRADED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LSG_DEGRADED && ext_any) |=> st_q.mode == LSG_HALTED); // R9

endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard
    import lsg_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int N_EXT        = 4,
    parameter int WATCH_CYCLES = 1024,
    parameter int CMP_COPIES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_valid,
    input  logic [N_EXT-1:0]  ext_fault,
    input  logic              recov_done,
    input  logic              degrade_en,
    input  logic              healthy_sel,
    output logic              rollback_req,
    output logic              halt,
    output logic              out_en,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic [1:0]        sel_proc,
    output logic [2:0]        fault_status
);

    lsg_mode_e             mode;
    logic                  cmp_en;
    logic [CMP_COPIES-1:0] miss_vec;
    logic                  cmp_fault;
    logic                  ext_any;

    assign cmp_en = (mode != LSG_DEGRADED) && (mode != LSG_HALTED);

    for (genvar gi = 0; gi < CMP_COPIES; gi++) begin : g_cmp
        lsg_cmp #(.DATA_W(DATA_W)) i_cmp (
            .en      (cmp_en),
            .a_data  (a_data),
            .a_valid (a_valid),
            .b_data  (b_data),
            .b_valid (b_valid),
            .miss    (miss_vec[gi])
        );
    end

    // A clean verdict needs every copy to agree that there is no mismatch.
    assign cmp_fault = |miss_vec;
    assign ext_any   = |ext_fault;

    lsg_ctrl #(.WATCH_CYCLES(WATCH_CYCLES)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_fault  (cmp_fault),
        .ext_any    (ext_any),
        .recov_done (recov_done),
        .degrade_en (degrade_en),
        .mode       (mode)
    );

    always_comb begin
        rollback_req = (mode == LSG_RECOVER);
        halt         = (mode == LSG_HALTED);
        out_en       = (mode != LSG_HALTED);
        fault_status = mode;
        out_data     = '0;
        out_valid    = 1'b0;
        sel_proc     = 2'b00;
        case (mode)
            LSG_HALTED: begin
                sel_proc = 2'b00;
            end
            LSG_DEGRADED: begin
                sel_proc  = healthy_sel ? 2'b10 : 2'b01;
                out_data  = healthy_sel ? b_data : a_data;
                out_valid = healthy_sel ? b_valid : a_valid;
            end
            default: begin
                sel_proc  = 2'b11;
                out_data  = a_data;
                out_valid = a_valid;
            end
        endcase
    end

    AST_SPLIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LSG_NORMAL && (a_valid != b_valid)) |=> rollback_req); // R2
    AST_EXT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LSG_NORMAL && ext_any) |=> rollback_req); // R3
    AST_HALT_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!out_en && !out_valid && sel_proc == 2'b00)); // R6
    AST_DEGRADED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_status == 3'd3 |-> $onehot(sel_proc)); // R8
    AST_DEGRADED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status == 3'd3 && !ext_any) |=> fault_status == 3'd3); // R8

endmodule

// File: tb/test_lockstep_guard.sv
`timescale 1ns/1ps
module test_lockstep_guard;

    localparam int DW = 16;
    localparam int NE = 2;
    localparam int WC = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] a_data, b_data;
    logic          a_valid, b_valid;
    logic [NE-1:0] ext_fault;
    logic          recov_done, degrade_en, healthy_sel;
    logic          rollback_req, halt, out_en, out_valid;
    logic [DW-1:0] out_data;
    logic [1:0]    sel_proc;
    logic [2:0]    fault_status;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    lockstep_guard #(.DATA_W(DW), .N_EXT(NE), .WATCH_CYCLES(WC), .CMP_COPIES(2)) i_lockstep_guard (
        .clk(clk), .rst_n(rst_n),
        .a_data(a_data), .a_valid(a_valid), .b_data(b_data), .b_valid(b_valid),
        .ext_fault(ext_fault), .recov_done(recov_done),
        .degrade_en(degrade_en), .healthy_sel(healthy_sel),
        .rollback_req(rollback_req), .halt(halt), .out_en(out_en),
        .out_data(out_data), .out_valid(out_valid),
        .sel_proc(sel_proc), .fault_status(fault_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        a_data = '0; b_data = '0; a_valid = 1'b0; b_valid = 1'b0;
        ext_fault = '0; recov_done = 1'b0; degrade_en = 1'b0; healthy_sel = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic drive_pair(input logic [DW-1:0] a, input logic av, input logic [DW-1:0] b, input logic bv);
        a_data = a; a_valid = av; b_data = b; b_valid = bv;
    endtask

    task automatic enter_watch();
        do_reset();
        drive_pair(16'h1111, 1'b1, 16'h2222, 1'b1);
        step();
        drive_pair(16'h3333, 1'b1, 16'h3333, 1'b1);
        recov_done = 1'b1;
        step();
        recov_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 status", fault_status, 3'd0);
        chk("R10 out_en", out_en, 1'b1);
        chk("R10 halt", halt, 1'b0);
        chk("R10 rollback", rollback_req, 1'b0);
        chk("R10 sel", sel_proc, 2'b11);
    endtask

    task automatic t_match();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            drive_pair(16'(16'h0F0F * i + 3), 1'b1, 16'(16'h0F0F * i + 3), 1'b1);
            step();
            chk("R1 equal words no fault", fault_status, 3'd0);
            chk("R1 out_data from A", out_data, 16'(16'h0F0F * i + 3));
        end
        drive_pair(16'hAAAA, 1'b0, 16'h5555, 1'b0);
        step();
        chk("R2 both invalid no fault", fault_status, 3'd0);
    endtask

    task automatic t_data_mismatch();
        do_reset();
        drive_pair(16'h1234, 1'b1, 16'h1235, 1'b1);
        step();
        chk("R1 mismatch status", fault_status, 3'd1);
        chk("R1 rollback", rollback_req, 1'b1);
    endtask

    task automatic t_one_sided();
        do_reset();
        drive_pair(16'h4444, 1'b1, 16'h4444, 1'b0);
        step();
        chk("R2 A-only strobe", fault_status, 3'd1);
        do_reset();
        drive_pair(16'h4444, 1'b0, 16'h4444, 1'b1);
        step();
        chk("R2 B-only strobe", fault_status, 3'd1);
    endtask

    task automatic t_ext();
        for (int b = 0; b < NE; b++) begin
            do_reset();
            drive_pair(16'h0101, 1'b1, 16'h0101, 1'b1);
            ext_fault = NE'(1) << b;
            step();
            ext_fault = '0;
            chk("R3 ext fault bit", fault_status, 3'd1);
        end
    endtask

    task automatic t_recover_hold();
        do_reset();
        drive_pair(16'h0001, 1'b1, 16'h0002, 1'b1);
        step();
        ext_fault = 2'b11;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R4 rollback held", rollback_req, 1'b1);
            chk("R4 faults ignored", fault_status, 3'd1);
        end
        ext_fault = '0;
        drive_pair(16'h0001, 1'b1, 16'h0001, 1'b1);
        recov_done = 1'b1;
        step();
        recov_done = 1'b0;
        chk("R4 watch entered", fault_status, 3'd2);
        chk("R4 rollback dropped", rollback_req, 1'b0);
    endtask

    task automatic t_watch_expire();
        enter_watch();
        for (int i = 0; i < WC - 1; i++) step();
        chk("R5 still watching on last cycle", fault_status, 3'd2);
        step();
        chk("R5 back to normal", fault_status, 3'd0);
        drive_pair(16'h0001, 1'b1, 16'h0003, 1'b1);
        step();
        chk("R5 restarts at first stage", fault_status, 3'd1);
    endtask

    task automatic t_halt();
        enter_watch();
        for (int i = 0; i < 4; i++) step();
        drive_pair(16'h0007, 1'b1, 16'h0008, 1'b1);
        step();
        chk("R6 halted", fault_status, 3'd4);
        chk("R6 halt", halt, 1'b1);
        chk("R6 out_en low", out_en, 1'b0);
        chk("R6 out_valid low", out_valid, 1'b0);
        chk("R6 sel none", sel_proc, 2'b00);
        drive_pair(16'h0007, 1'b1, 16'h0007, 1'b1);
        recov_done = 1'b1; degrade_en = 1'b1; healthy_sel = 1'b1;
        for (int i = 0; i < 3; i++) step();
        recov_done = 1'b0;
        for (int i = 0; i < WC + 2; i++) step();
        chk("R7 halt sticky", fault_status, 3'd4);
        chk("R7 out_en stays low", out_en, 1'b0);
    endtask

    task automatic t_degrade();
        enter_watch();
        degrade_en = 1'b1;
        healthy_sel = 1'b1;
        step();
        ext_fault = 2'b01;
        step();
        ext_fault = '0;
        chk("R8 degraded", fault_status, 3'd3);
        chk("R8 out_en high", out_en, 1'b1);
        drive_pair(16'hA0A0, 1'b0, 16'hB0B0, 1'b1);
        step();
        chk("R8 mismatch ignored", fault_status, 3'd3);
        chk("R8 data from B", out_data, 16'hB0B0);
        chk("R8 valid from B", out_valid, 1'b1);
        chk("R8 sel B", sel_proc, 2'b10);
        healthy_sel = 1'b0;
        #1;
        chk("R8 data from A", out_data, 16'hA0A0);
        chk("R8 valid from A", out_valid, 1'b0);
        chk("R8 sel A", sel_proc, 2'b01);
        ext_fault = 2'b10;
        step();
        ext_fault = '0;
        chk("R9 degraded ext fault halts", fault_status, 3'd4);
        chk("R9 out_en low", out_en, 1'b0);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_match();
        t_data_mismatch();
        t_one_sided();
        t_ext();
        t_recover_hold();
        t_watch_expire();
        t_halt();
        t_degrade();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule